// File: doc/BRIEF.md
# Dual-Function Port Bit Array

This block is a byte-wide port where every bit can be ordinary latched I/O or a carrier for a peripheral signal, such as a serial receive or transmit line, an external interrupt, a counter input, or an external-memory read or write strobe. Each bit has an output latch and an alternate-output line from its peripheral. The pad's pull-down is on whenever either of the two is 0. A weak pull-up is on whenever the pull-down is off, which gives quasi-bidirectional behaviour.

To use a bit as general I/O, hold its alternate-output line at 1. Peripherals that are idle are expected to leave their line at 1. To hand a bit to its peripheral, set its latch to 1 so that the alternate-output line alone sets the pin. The pad level is synchronized and then sent to two places: the internal read path and the alternate input of every bit. Only the peripherals that need that input use it. A read-modify-write access selects the latch on the read path. Any other read selects the synchronized pin.

Software may rewrite the whole byte. It may also set or clear a single bit, which leaves the other bits untouched and keeps alternate-function bits safe. Reset loads 1 into every latch bit.

Top module: `dfport_array`

## Requirements
- R1: While reset is held and right after it, every latch bit is 1, `drive_low` is all 0 and `pullup_en` is all 1. With the alternate lines at 1, reading the latch returns 0xFF.
- R2: A byte write (`wr_en` high, `bit_en` low) loads `wr_data` into the latch at the next rising clock edge.
- R3: A single-bit write (`bit_en` high) at the next edge gives bit `bit_sel` the value `bit_val`, where 0 means clear and 1 means set. All other latch bits keep their values.
- R4: When `wr_en` and `bit_en` are both high in one cycle, the addressed bit takes `bit_val` and every other bit takes the value from `wr_data`.
- R5: For each bit i, `drive_low[i]` is high exactly when latch bit i is 0 or `alt_out[i]` is 0. The change appears in the same cycle, with no added register.
- R6: For each bit i, `pullup_en[i]` is the inverse of `drive_low[i]`, so the two are never high together.
- R7: With `rd_latch_sel` = 1 (read-modify-write source), `rd_data` equals the latch contents, whatever the pin level.
- R8: With `rd_latch_sel` = 0, `rd_data` equals `pin_in` after SYNC_STAGES rising edges (default 2).
- R9: `alt_in` always carries the same synchronized pin level as the pin read path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets latches to 1 |
| wr_en | input | 1 | Whole-byte latch write strobe |
| wr_data | input | WIDTH | Byte value to load |
| bit_en | input | 1 | Single-bit write strobe |
| bit_sel | input | IDX_W | Index of the bit to write |
| bit_val | input | 1 | Value for the addressed bit (1 = set, 0 = clear) |
| rd_latch_sel | input | 1 | Read source: 1 = latch, 0 = pin |
| rd_data | output | WIDTH | Read data toward the internal bus |
| alt_out | input | WIDTH | Alternate-output lines from peripherals (idle = 1) |
| alt_in | output | WIDTH | Synchronized pin level to peripherals |
| pin_in | input | WIDTH | Sensed pad level |
| drive_low | output | WIDTH | Pad pull-down enable |
| pullup_en | output | WIDTH | Pad weak pull-up enable |

## Verification
A byte write and a single-bit write can land in the same cycle, for example when firmware rewrites the port while a bit instruction retires. The bench provokes this by raising `wr_en` and `bit_en` on the same negative edge, for every bit index and both bit values, with a byte pattern whose bit differs from `bit_val`. It then reads the latch through the read-modify-write path. The expected value is the byte with the addressed bit replaced, and any other result is reported. The latch sweep runs under several alternate-output and pad patterns. Because the bench models the pad as a wired AND, the latch and the pin read are judged against each other.

// File: rtl/dfport_pkg.sv
package dfport_pkg;

   // read source select encoding
   typedef enum logic {
      RD_SRC_PIN   = 1'b0,
      RD_SRC_LATCH = 1'b1
   } rd_src_e;

   // pad drive state of one bit
   typedef struct packed {
      logic pull_dn;
      logic pull_up;
   } pad_ctl_t;

   localparam int unsigned MAX_SYNC_STAGES = 4;

   function automatic int unsigned idx_width(input int unsigned w);
      return (w > 1) ? $clog2(w) : 1;
   endfunction

endpackage

// File: rtl/dfport_latch_bank.sv
module dfport_latch_bank #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             bit_en,
   input  logic [IDX_W-1:0] bit_sel,
   input  logic             bit_val,
   output logic [WIDTH-1:0] latch_q
);

   localparam logic [WIDTH-1:0] RST_VAL = '1;

   logic [WIDTH-1:0] nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic hit;
      assign hit = bit_en && (bit_sel == IDX_W'(i));
      // the single-bit write takes precedence over the byte write
      always_comb begin
         if (hit)
            nxt[i] = bit_val;
         else if (wr_en)
            nxt[i] = wr_data[i];
         else
            nxt[i] = latch_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         latch_q <= RST_VAL;
      else
         latch_q <= nxt;
   end

endmodule

// File: rtl/dfport_pin_sync.sv
module dfport_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin_raw,
   output logic [WIDTH-1:0] pin_sync
);

   if (STAGES == 0) begin : g_bypass
      assign pin_sync = pin_raw;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++)
               stg[s] <= '1;
         end else begin
            stg[0] <= pin_raw;
            for (int s = 1; s < int'(STAGES); s++)
               stg[s] <= stg[s-1];
         end
      end
      assign pin_sync = stg[STAGES-1];
   end

endmodule

// File: rtl/dfport_pad_ctl.sv
module dfport_pad_ctl
   import dfport_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] alt_out,
   output logic [WIDTH-1:0] drive_low,
   output logic [WIDTH-1:0] pullup_en
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      pad_ctl_t ctl;
      logic     release_hi;
      // either source at 0 pulls the pin down
      assign release_hi  = latch_q[i] & alt_out[i];
      assign ctl.pull_dn = ~release_hi;
      assign ctl.pull_up = release_hi;
      assign drive_low[i] = ctl.pull_dn;
      assign pullup_en[i] = ctl.pull_up;
   end

endmodule

// File: rtl/dfport_array.sv
module dfport_array
   import dfport_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDX_W       = idx_width(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             bit_en,
   input  logic [IDX_W-1:0] bit_sel,
   input  logic             bit_val,
   input  logic             rd_latch_sel,
   output logic [WIDTH-1:0] rd_data,
   input  logic [WIDTH-1:0] alt_out,
   output logic [WIDTH-1:0] alt_in,
   input  logic [WIDTH-1:0] pin_in,
   output logic [WIDTH-1:0] drive_low,
   output logic [WIDTH-1:0] pullup_en
);

   if (WIDTH < 1 || WIDTH > 64) begin : g_bad_width
      $error("dfport_array: WIDTH must be 1..64");
   end
   if (SYNC_STAGES > MAX_SYNC_STAGES) begin : g_bad_sync
      $error("dfport_array: SYNC_STAGES too large");
   end
   if (IDX_W < idx_width(WIDTH)) begin : g_bad_idx
      $error("dfport_array: IDX_W too narrow for WIDTH");
   end

   logic [WIDTH-1:0] latch_q;
   logic [WIDTH-1:0] pin_s;
   rd_src_e          rd_src;

   dfport_latch_bank #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .bit_en  (bit_en),
      .bit_sel (bit_sel),
      .bit_val (bit_val),
      .latch_q (latch_q)
   );

   dfport_pad_ctl #(.WIDTH(WIDTH)) u_pad (
      .latch_q   (latch_q),
      .alt_out   (alt_out),
      .drive_low (drive_low),
      .pullup_en (pullup_en)
   );

   dfport_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_raw  (pin_in),
      .pin_sync (pin_s)
   );

   assign rd_src  = rd_src_e'(rd_latch_sel);
   assign rd_data = (rd_src == RD_SRC_LATCH) ? latch_q : pin_s;
   assign alt_in  = pin_s;

endmodule

// File: rtl/dfport_array_chk.sv
module dfport_array_chk #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic             bit_en,
   input logic [IDX_W-1:0] bit_sel,
   input logic             bit_val,
   input logic             rd_latch_sel,
   input logic [WIDTH-1:0] rd_data,
   input logic [WIDTH-1:0] alt_in,
   input logic [WIDTH-1:0] latch_q,
   input logic [WIDTH-1:0] drive_low,
   input logic [WIDTH-1:0] pullup_en
);

   // R2
   byte_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !bit_en) |=> (latch_q == $past(wr_data)));

   // R3
   bit_write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !wr_en) |=> (latch_q[$past(bit_sel)] == $past(bit_val)));

   // R3
   bit_write_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !wr_en) |=>
      (((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(bit_sel))) == '0));

   // R4
   merged_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && wr_en) |=>
      ((latch_q[$past(bit_sel)] == $past(bit_val)) &&
       (((latch_q ^ $past(wr_data)) & ~(WIDTH'(1) << $past(bit_sel))) == '0)));

   // R6
   pad_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((drive_low & pullup_en) == '0) && ((drive_low | pullup_en) == '1));

   // R7
   latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_latch_sel |-> (rd_data == latch_q));

   // R9
   alt_matches_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_latch_sel |-> (rd_data == alt_in));

endmodule

bind dfport_array dfport_array_chk #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .bit_en       (bit_en),
   .bit_sel      (bit_sel),
   .bit_val      (bit_val),
   .rd_latch_sel (rd_latch_sel),
   .rd_data      (rd_data),
   .alt_in       (alt_in),
   .latch_q      (latch_q),
   .drive_low    (drive_low),
   .pullup_en    (pullup_en)
);

// File: tb/dfport_array_test.sv
`timescale 1ns/1ps
module dfport_array_test;

   localparam int W  = 8;
   localparam int SS = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         bit_en = 1'b0;
   logic [2:0]   bit_sel = '0;
   logic         bit_val = 1'b0;
   logic         rd_latch_sel = 1'b0;
   logic [W-1:0] rd_data;
   logic [W-1:0] alt_out = '1;
   logic [W-1:0] alt_in;
   logic [W-1:0] ext_lvl = '1;
   logic [W-1:0] pin_in;
   logic [W-1:0] drive_low;
   logic [W-1:0] pullup_en;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   // pad model: external level wired-AND with the pull-down
   assign pin_in = ext_lvl & ~drive_low;

   dfport_array #(.WIDTH(W), .SYNC_STAGES(SS)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .bit_en(bit_en), .bit_sel(bit_sel), .bit_val(bit_val),
      .rd_latch_sel(rd_latch_sel), .rd_data(rd_data),
      .alt_out(alt_out), .alt_in(alt_in), .pin_in(pin_in),
      .drive_low(drive_low), .pullup_en(pullup_en)
   );

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   logic [W-1:0] alt_pat [4];
   logic [W-1:0] ext_pat [4];

   initial begin
      alt_pat[0] = 8'hFF; alt_pat[1] = 8'h0F; alt_pat[2] = 8'hA5; alt_pat[3] = 8'h7E;
      ext_pat[0] = 8'hFF; ext_pat[1] = 8'h00; ext_pat[2] = 8'h3C; ext_pat[3] = 8'hC3;

      // R1: state during and after reset
      wait_neg(2);
      rd_latch_sel = 1'b1;
      #1;
      chk("R1 latch in reset", rd_data, 8'hFF);
      chk("R1 drive_low in reset", drive_low, 8'h00);
      rst_n = 1'b1;
      wait_neg(1);
      chk("R1 latch after reset", rd_data, 8'hFF);
      chk("R1 pullup after reset", pullup_en, 8'hFF);

      // R2 R5 R6 R7 R8 R9: sweep every latch value over alt/ext patterns
      for (int p = 0; p < 4; p++) begin
         for (int v = 0; v < 256; v++) begin
            logic [W-1:0] lv, rel, pexp;
            lv = W'(v);
            alt_out = alt_pat[p];
            ext_lvl = ext_pat[(p + v) % 4];
            wr_en = 1'b1; wr_data = lv;
            rd_latch_sel = 1'b1;
            wait_neg(1);
            wr_en = 1'b0; wr_data = ~lv;
            rel  = lv & alt_out;
            pexp = ext_lvl & rel;
            chk("R2 byte write", rd_data, lv);
            chk("R5 drive_low", drive_low, ~rel);
            chk("R6 pullup_en", pullup_en, rel);
            wait_neg(SS + 1);
            chk("R7 latch read ignores pin", rd_data, lv);
            rd_latch_sel = 1'b0;
            #1;
            chk("R8 pin read", rd_data, pexp);
            chk("R9 alt_in", alt_in, pexp);
         end
      end

      // R5: alternate output alone drives the pin when latch is 1
      alt_out = 8'hFF; ext_lvl = 8'hFF;
      wr_en = 1'b1; wr_data = 8'hFF;
      wait_neg(1);
      wr_en = 1'b0;
      alt_out = 8'h5A;
      #1;
      chk("R5 same-cycle alt drive", drive_low, 8'hA5);

      // R3: single-bit set and clear leave the rest unchanged
      alt_out = 8'hFF;
      rd_latch_sel = 1'b1;
      for (int i = 0; i < W; i++) begin
         for (int b = 0; b < 2; b++) begin
            logic [W-1:0] base, exp;
            base = (b == 1) ? 8'h00 : 8'hFF;
            base = base ^ W'(8'h24 << (i % 3));
            wr_en = 1'b1; wr_data = base;
            wait_neg(1);
            wr_en = 1'b0;
            bit_en = 1'b1; bit_sel = 3'(i); bit_val = b[0];
            wait_neg(1);
            bit_en = 1'b0;
            exp = base;
            exp[i] = b[0];
            chk("R3 single-bit write", rd_data, exp);
         end
      end

      // R4: byte write and bit write in the same cycle
      for (int i = 0; i < W; i++) begin
         for (int b = 0; b < 2; b++) begin
            logic [W-1:0] d, exp;
            d = (b == 1) ? 8'h00 : 8'hFF;
            d = d ^ W'(8'h81 >> (i % 2));
            d[i] = ~b[0];
            wr_en = 1'b1; wr_data = d;
            bit_en = 1'b1; bit_sel = 3'(i); bit_val = b[0];
            wait_neg(1);
            wr_en = 1'b0; bit_en = 1'b0;
            exp = d;
            exp[i] = b[0];
            chk("R4 merged write", rd_data, exp);
         end
      end

      // R1: reset again restores all ones
      rst_n = 1'b0;
      #1;
      chk("R1 latch on re-reset", rd_data, 8'hFF);
      wait_neg(1);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int c = 0; c < 100000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule